// File: doc/BRIEF.md
# Thermal Trip Controller with Ownership Semaphore

This block watches a digital temperature sample and raises a registered trip flag when the sample reaches a programmable threshold. Once the flag is up, a programmable hysteresis margin is added to the release point. The flag therefore drops only after the temperature has fallen a set number of LSBs below the threshold. This stops the flag from toggling when the sample sits near the threshold.

It also picks one of two external comparator status lines, "catastrophic" or "hot", and drives the chosen one out as a registered status. The select bit can be frozen by an external lock input. A one-bit claim flag lets independent software agents agree on who owns the sensor: a read that returns 0 means the reader now owns it, and a write of 1 releases it.

All configuration sits behind a small synchronous register port. Read data is registered and appears one clock after the read strobe.

Top module: `thermal_trip_ctrl`

## Requirements
- R1: After reset, the threshold reads `THRESH_RST`, the control register reads 0, the claim flag is 0, `trip_o` and `sel_status_o` are 0, and `reg_rd_data_o` is 0.
- R2: While `trip_o` is low, a sample on `temp_i` at or above the threshold drives `trip_o` high on the next clock.
- R3: With a hysteresis code of 0, a tripped flag clears on the clock after the sample falls below the threshold.
- R4: With a hysteresis code N (control bits [3:0]), a tripped flag stays high while sample + N ≥ threshold and clears on the clock after sample + N < threshold. Before a trip the margin is not applied, and no underflow occurs near zero.
- R5: `sel_status_o` takes, one clock later, the value of `cat_cmp_i` when the select bit (control bit 4) is 0 and of `hot_cmp_i` when it is 1.
- R6: While `sel_lock_i` is high, writes to the control register leave the select bit unchanged but still update the hysteresis code.
- R7: After reset, the first read of the claim register (address 2, bit 0) returns 0 and every later read returns 1.
- R8: Writing 1 to claim bit 0 makes the next read return 0. Writing 0 to it has no effect.
- R9: When a read of the claim register and a write of 1 to it occur in the same cycle, the read returns the value held before the access and the stored flag becomes 0.
- R10: Claim-flag activity has no effect on `trip_o` or `sel_status_o`.
- R11: Register map: address 0 holds the threshold in bits [TEMP_W-1:0]; address 1 holds the hysteresis code in [3:0] and the select bit in [4]; address 3 returns `trip_o` in bit 0 and `sel_status_o` in bit 1. Unused bits read 0. Read data is registered on the read strobe and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr_i | input | 2 | Register address |
| reg_wr_en_i | input | 1 | Write strobe |
| reg_wr_data_i | input | DATA_W | Write data |
| reg_rd_en_i | input | 1 | Read strobe |
| reg_rd_data_o | output | DATA_W | Registered read data |
| temp_i | input | TEMP_W | Digital temperature sample |
| cat_cmp_i | input | 1 | Catastrophic comparator status |
| hot_cmp_i | input | 1 | Hot comparator status |
| sel_lock_i | input | 1 | Freezes the source select bit |
| trip_o | output | 1 | Registered trip flag with hysteresis |
| sel_status_o | output | 1 | Registered selected comparator status |

## Verification
The bench builds the block with an 8-bit sample, a 4-bit hysteresis code, 16-bit register data and a reset threshold of 100. With these values the whole hysteresis range, 0 to 15, can be placed around both a mid-range threshold and a threshold close to zero, where the release point would underflow if computed by subtraction. Random temperatures are drawn near the programmed threshold so that trips and releases happen often, while random register traffic, lock changes and claim accesses run in the same cycles.

// File: rtl/thermtrip_pkg.sv
package thermtrip_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_THRESH = 2'd0,
    REG_CTRL   = 2'd1,
    REG_CLAIM  = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;

  localparam int STAT_TRIP_BIT = 0;
  localparam int STAT_SEL_BIT  = 1;
endpackage

// File: rtl/tt_claim_flag.sv
module tt_claim_flag (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit_i,
  input  logic release_i,
  output logic in_use_o
);
  logic in_use_q;

  // Release has priority over the read that sets the flag
  always_ff @(posedge clk) begin
    if (rst)            in_use_q <= 1'b0;
    else if (release_i) in_use_q <= 1'b0;
    else if (rd_hit_i)  in_use_q <= 1'b1;
  end

  assign in_use_o = in_use_q;

  assert_release_clears_R9: assert property (@(posedge clk) disable iff (rst)
    release_i |=> !in_use_o);
  assert_read_claims_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_hit_i && !release_i) |=> in_use_o);
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_hit_i && !release_i) |=> $stable(in_use_o));
endmodule

// File: rtl/tt_hyst_cmp.sv
module tt_hyst_cmp #(
  parameter int TEMP_W = 8,
  parameter int HYST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] thresh_i,
  input  logic [HYST_W-1:0] hyst_i,
  output logic              trip_o
);
  localparam int EXT_W = TEMP_W + 1;

  logic             trip_q;
  logic             trip_d;
  logic [EXT_W-1:0] hold_sum;
  logic [EXT_W-1:0] thresh_ext;
  logic             at_or_above;
  logic             still_held;

  // Margin is added to the sample instead of subtracted from the threshold
  always_comb begin
    hold_sum    = EXT_W'(temp_i) + EXT_W'(hyst_i);
    thresh_ext  = EXT_W'(thresh_i);
    at_or_above = (temp_i >= thresh_i);
    still_held  = (hold_sum >= thresh_ext);
    trip_d      = trip_q ? still_held : at_or_above;
  end

  always_ff @(posedge clk) begin
    if (rst) trip_q <= 1'b0;
    else     trip_q <= trip_d;
  end

  assign trip_o = trip_q;

  assert_trip_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (!trip_o && temp_i >= thresh_i) |=> trip_o);
  assert_rise_needs_reach_R2: assert property (@(posedge clk) disable iff (rst)
    (!trip_o && temp_i < thresh_i) |=> !trip_o);
  assert_release_point_R4: assert property (@(posedge clk) disable iff (rst)
    (trip_o && (EXT_W'(temp_i) + EXT_W'(hyst_i)) < EXT_W'(thresh_i)) |=> !trip_o);
  assert_zero_margin_R3: assert property (@(posedge clk) disable iff (rst)
    (trip_o && hyst_i == '0 && temp_i >= thresh_i) |=> trip_o);
endmodule

// File: rtl/tt_src_sel.sv
module tt_src_sel #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [$clog2(NUM_SRC)-1:0] sel_i,
  output logic               status_o
);
  logic status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= 1'b0;
    else     status_q <= src_i[sel_i];
  end

  assign status_o = status_q;

  assert_src0_route_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_i == '0) |=> status_o == $past(src_i[0]));
  assert_src_last_route_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_i == ($clog2(NUM_SRC))'(NUM_SRC-1)) |=> status_o == $past(src_i[NUM_SRC-1]));
endmodule

// File: rtl/tt_regfile.sv
module tt_regfile
  import thermtrip_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int HYST_W     = 4,
  parameter int DATA_W     = 16,
  parameter int THRESH_RST = 100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  input  logic                  lock_i,
  input  logic                  in_use_i,
  input  logic                  trip_i,
  input  logic                  status_i,
  output logic [TEMP_W-1:0]     thresh_o,
  output logic [HYST_W-1:0]     hyst_o,
  output logic                  sel_o,
  output logic [DATA_W-1:0]     rd_data_o
);
  localparam int SEL_BIT = HYST_W;

  logic [TEMP_W-1:0] thresh_q;
  logic [HYST_W-1:0] hyst_q;
  logic              sel_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_thresh;
  logic              wr_ctrl;

  assign wr_thresh = wr_en_i && (addr_i == REG_THRESH);
  assign wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_q <= TEMP_W'(THRESH_RST);
      hyst_q   <= '0;
      sel_q    <= 1'b0;
    end else begin
      if (wr_thresh) thresh_q <= wr_data_i[TEMP_W-1:0];
      if (wr_ctrl) begin
        hyst_q <= wr_data_i[HYST_W-1:0];
        if (!lock_i) sel_q <= wr_data_i[SEL_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      REG_THRESH: rd_mux[TEMP_W-1:0] = thresh_q;
      REG_CTRL: begin
        rd_mux[HYST_W-1:0] = hyst_q;
        rd_mux[SEL_BIT]    = sel_q;
      end
      REG_CLAIM: rd_mux[0] = in_use_i;
      default: begin
        rd_mux[STAT_TRIP_BIT] = trip_i;
        rd_mux[STAT_SEL_BIT]  = status_i;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_mux;
  end

  assign thresh_o  = thresh_q;
  assign hyst_o    = hyst_q;
  assign sel_o     = sel_q;
  assign rd_data_o = rd_data_q;

  assert_lock_freezes_sel_R6: assert property (@(posedge clk) disable iff (rst)
    lock_i |=> sel_o == $past(sel_o));
  assert_read_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
  assert_ctrl_write_hyst_R6: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> hyst_o == $past(wr_data_i[HYST_W-1:0]));
endmodule

// File: rtl/thermal_trip_ctrl.sv
module thermal_trip_ctrl
  import thermtrip_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int HYST_W     = 4,
  parameter int DATA_W     = 16,
  parameter int THRESH_RST = 100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_wr_en_i,
  input  logic [DATA_W-1:0]     reg_wr_data_i,
  input  logic                  reg_rd_en_i,
  output logic [DATA_W-1:0]     reg_rd_data_o,
  input  logic [TEMP_W-1:0]     temp_i,
  input  logic                  cat_cmp_i,
  input  logic                  hot_cmp_i,
  input  logic                  sel_lock_i,
  output logic                  trip_o,
  output logic                  sel_status_o
);
  logic [TEMP_W-1:0] thresh;
  logic [HYST_W-1:0] hyst;
  logic              src_sel;
  logic              in_use;
  logic              claim_rd;
  logic              claim_release;
  logic              trip;
  logic              status;

  assign claim_rd      = reg_rd_en_i && (reg_addr_i == REG_CLAIM);
  assign claim_release = reg_wr_en_i && (reg_addr_i == REG_CLAIM) && reg_wr_data_i[0];

  tt_claim_flag claim_i (
    .clk      (clk),
    .rst      (rst),
    .rd_hit_i (claim_rd),
    .release_i(claim_release),
    .in_use_o (in_use)
  );

  tt_regfile #(
    .TEMP_W    (TEMP_W),
    .HYST_W    (HYST_W),
    .DATA_W    (DATA_W),
    .THRESH_RST(THRESH_RST)
  ) regs_i (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (reg_addr_i),
    .wr_en_i  (reg_wr_en_i),
    .wr_data_i(reg_wr_data_i),
    .rd_en_i  (reg_rd_en_i),
    .lock_i   (sel_lock_i),
    .in_use_i (in_use),
    .trip_i   (trip),
    .status_i (status),
    .thresh_o (thresh),
    .hyst_o   (hyst),
    .sel_o    (src_sel),
    .rd_data_o(reg_rd_data_o)
  );

  tt_hyst_cmp #(
    .TEMP_W(TEMP_W),
    .HYST_W(HYST_W)
  ) cmp_i (
    .clk     (clk),
    .rst     (rst),
    .temp_i  (temp_i),
    .thresh_i(thresh),
    .hyst_i  (hyst),
    .trip_o  (trip)
  );

  tt_src_sel #(
    .NUM_SRC(2)
  ) mux_i (
    .clk     (clk),
    .rst     (rst),
    .src_i   ({hot_cmp_i, cat_cmp_i}),
    .sel_i   (src_sel),
    .status_o(status)
  );

  assign trip_o       = trip;
  assign sel_status_o = status;

  // R10: claim accesses alone never move the routed status
  assert_claim_isolated_R10: assert property (@(posedge clk) disable iff (rst)
    (claim_rd || claim_release) && !reg_wr_en_i && !src_sel && $stable(cat_cmp_i)
      |=> sel_status_o == $past(cat_cmp_i));
endmodule

// File: tb/thermal_trip_ctrl_tb_top.sv
module thermal_trip_ctrl_tb_top;
  localparam int TEMP_W = 8;
  localparam int HYST_W = 4;
  localparam int DATA_W = 16;
  localparam int THR0   = 100;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        addr = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] wd = '0;
  logic              re = 1'b0;
  logic [DATA_W-1:0] rd;
  logic [TEMP_W-1:0] temp = '0;
  logic              cat = 1'b0;
  logic              hot = 1'b0;
  logic              lock = 1'b0;
  logic              trip;
  logic              stat;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference state
  logic [TEMP_W-1:0] m_thr  = TEMP_W'(THR0);
  logic [HYST_W-1:0] m_hyst = '0;
  logic              m_sel  = 1'b0;
  logic              m_use  = 1'b0;
  logic              m_trip = 1'b0;
  logic              m_stat = 1'b0;

  always #2 clk = ~clk;

  thermal_trip_ctrl #(
    .TEMP_W(TEMP_W), .HYST_W(HYST_W), .DATA_W(DATA_W), .THRESH_RST(THR0)
  ) dut_i (
    .clk(clk), .rst(rst), .reg_addr_i(addr), .reg_wr_en_i(we),
    .reg_wr_data_i(wd), .reg_rd_en_i(re), .reg_rd_data_o(rd),
    .temp_i(temp), .cat_cmp_i(cat), .hot_cmp_i(hot), .sel_lock_i(lock),
    .trip_o(trip), .sel_status_o(stat)
  );

  function automatic logic [DATA_W-1:0] exp_read(input logic [1:0] a);
    logic [DATA_W-1:0] v = '0;
    case (a)
      2'd0: v[TEMP_W-1:0] = m_thr;
      2'd1: begin v[HYST_W-1:0] = m_hyst; v[HYST_W] = m_sel; end
      2'd2: v[0] = m_use;
      default: begin v[0] = m_trip; v[1] = m_stat; end
    endcase
    return v;
  endfunction

  function automatic logic exp_trip(input logic [TEMP_W-1:0] t);
    if (m_trip) return ({1'b0, t} + (TEMP_W+1)'(m_hyst)) >= {1'b0, m_thr};
    return t >= m_thr;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [DATA_W-1:0] d, input logic [TEMP_W-1:0] t,
                      input logic c, input logic h, input logic lk, input string tag);
    logic [DATA_W-1:0] e_rd;
    logic              n_trip, n_stat;
    @(negedge clk);
    we = w; re = r; addr = a; wd = d; temp = t; cat = c; hot = h; lock = lk;
    e_rd   = exp_read(a);
    n_trip = exp_trip(t);
    n_stat = m_sel ? h : c;
    if (w && a == 2'd0) m_thr = d[TEMP_W-1:0];
    if (w && a == 2'd1) begin
      m_hyst = d[HYST_W-1:0];
      if (!lk) m_sel = d[HYST_W];
    end
    if (w && a == 2'd2 && d[0]) m_use = 1'b0;
    else if (r && a == 2'd2)    m_use = 1'b1;
    m_trip = n_trip;
    m_stat = n_stat;
    @(posedge clk);
    #1;
    check(tag, "trip_o", DATA_W'(trip), DATA_W'(m_trip));
    check(tag, "sel_status_o", DATA_W'(stat), DATA_W'(m_stat));
    if (r) check(tag, "rd_data", rd, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "trip_o reset", DATA_W'(trip), '0);
    check("R1", "sel_status_o reset", DATA_W'(stat), '0);
    check("R1", "rd_data reset", rd, '0);
    @(negedge clk); rst = 1'b0;

    // R1 / R11 register reset values
    step(0, 1, 2'd0, '0, 8'd0, 0, 0, 0, "R1");
    step(0, 1, 2'd1, '0, 8'd0, 0, 0, 0, "R1");
    // R11 read data holds with no strobe
    step(0, 0, 2'd3, '0, 8'd0, 0, 0, 0, "R11");
    check("R11", "rd hold", rd, '0);
    // R7 first read 0, later reads 1
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R7");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R7");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R7");
    // R8 write 0 ignored, write 1 releases
    step(1, 0, 2'd2, 16'h0, 8'd0, 0, 0, 0, "R8");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R8");
    step(1, 0, 2'd2, 16'h1, 8'd0, 0, 0, 0, "R8");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R8");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R8");
    // R9 simultaneous read and release
    step(1, 1, 2'd2, 16'h1, 8'd0, 0, 0, 0, "R9");
    step(0, 1, 2'd2, '0, 8'd0, 0, 0, 0, "R9");
    // R2 / R3 zero margin
    step(0, 0, 2'd0, '0, 8'd99, 0, 0, 0, "R2");
    step(0, 0, 2'd0, '0, 8'd100, 0, 0, 0, "R2");
    step(0, 0, 2'd0, '0, 8'd100, 0, 0, 0, "R3");
    step(0, 0, 2'd0, '0, 8'd99, 0, 0, 0, "R3");
    // R4 margin of 6 around threshold 100
    step(1, 0, 2'd1, 16'h0006, 8'd95, 0, 0, 0, "R4");
    step(0, 0, 2'd0, '0, 8'd99, 0, 0, 0, "R4");
    step(0, 0, 2'd0, '0, 8'd100, 0, 0, 0, "R4");
    step(0, 0, 2'd0, '0, 8'd94, 0, 0, 0, "R4");
    step(0, 0, 2'd0, '0, 8'd93, 0, 0, 0, "R4");
    // R4 full margin near zero
    step(1, 0, 2'd0, 16'd10, 8'd0, 0, 0, 0, "R4");
    step(1, 0, 2'd1, 16'h000F, 8'd10, 0, 0, 0, "R4");
    step(0, 0, 2'd0, '0, 8'd0, 0, 0, 0, "R4");
    step(0, 1, 2'd3, '0, 8'd0, 0, 0, 0, "R11");
    // R5 source routing
    step(0, 0, 2'd0, '0, 8'd0, 1, 0, 0, "R5");
    step(1, 0, 2'd1, 16'h0010, 8'd0, 1, 0, 0, "R5");
    step(0, 0, 2'd0, '0, 8'd0, 1, 0, 0, "R5");
    step(0, 0, 2'd0, '0, 8'd0, 0, 1, 0, "R5");
    // R6 lock freezes select, margin still written
    step(1, 0, 2'd1, 16'h0003, 8'd0, 0, 1, 1, "R6");
    step(0, 1, 2'd1, '0, 8'd0, 0, 1, 1, "R6");
    step(0, 0, 2'd0, '0, 8'd0, 1, 0, 0, "R6");
    step(1, 0, 2'd1, 16'h0000, 8'd0, 1, 0, 0, "R6");
    step(0, 1, 2'd1, '0, 8'd0, 1, 0, 0, "R6");
    step(1, 0, 2'd0, 16'd100, 8'd0, 0, 0, 0, "R11");

    // Random traffic: R10 claim activity mixed with trip and routing
    for (int i = 0; i < 4000; i++) begin
      logic       w, r, c, h, lk;
      logic [1:0] a;
      logic [DATA_W-1:0] d;
      logic [TEMP_W-1:0] t;
      w  = ($urandom % 4) == 0;
      r  = ($urandom % 2) == 0;
      a  = 2'($urandom);
      d  = DATA_W'($urandom);
      if (a == 2'd0 && w) d[TEMP_W-1:0] = 8'd80 + 8'($urandom % 40);
      c  = 1'($urandom); h = 1'($urandom); lk = ($urandom % 3) == 0;
      t  = m_thr - 8'd20 + 8'($urandom % 40);
      step(w, r, a, d, t, c, h, lk, "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule